// File: doc/BRIEF.md
# Step Attenuator Programming Sequencer

This block sits on the host side of a 6-bit RF step attenuator and turns one command into the pin activity that programs the part. A command carries a 6-bit attenuation code and a mode flag, and it is taken through a valid/ready handshake. In serial mode the block shifts the code out on a data line against a generated bit clock, then pulses the latch strobe. In latched-parallel mode it places the code on six parallel lines and pulses the strobe across them.

Every edge is placed by counting system clock cycles. Each timing minimum is a parameter in picoseconds, and it is converted to a cycle count that is rounded up. After each update the block can also hold off the next one, so that a part running from its internal negative rail is never switched faster than 25 kHz. A level input chooses whether that holdoff applies. Its value is captured together with the command.

Top module: `atten_prog`

## Requirements
- R1: In serial mode the six code bits go out on `ser_data` starting with bit 5 and ending with bit 0. Each bit is presented while `ser_clk` is low and stays unchanged until `ser_clk` falls again, so it is stable for the whole low phase before each rising edge and the whole high phase after it.
- R2: For each bit, `ser_clk` is low for LO cycles and then high for HI cycles. LO is the largest of the low-time minimum, the data setup minimum and the period minimum less HI, each rounded up to cycles. HI is the larger of the high-time and data-hold minimums. With the defaults at 8 ns this gives LO=9 and HI=4.
- R3: `latch_en` stays low throughout the shift. After the last high phase ends, `ser_clk` stays low for GAP=2 cycles. Then `latch_en` is high for 4 cycles and returns low.
- R4: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_serial`=1 selects serial mode and 0 selects latched-parallel mode.
- R5: In parallel mode `par_code` takes the new code in the cycle after acceptance. `latch_en` rises 2 cycles later and is high for 2 cycles. The code is then held for 2 more cycles before the block can accept again.
- R6: If `holdoff_en` was 1 at acceptance, `cmd_ready` stays low for a further 5000 cycles (40 us) after the strobe sequence ends. If it was 0, no extra cycles are added.
- R7: `cmd_ready` is low from the cycle after acceptance until the whole sequence, holdoff included, is complete. A command offered while `cmd_ready` is low is not taken and has no effect on any output.
- R8: After reset and while idle: `cmd_ready`=1, `ser_clk`=0, `latch_en`=0, `ser_data`=0 and `par_code`=0. `par_code` keeps the last parallel code, and a serial command does not change it. `ser_data` returns to 0 when the serial strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_code | input | 6 | Attenuation code, bit 5 is the largest weight |
| cmd_serial | input | 1 | 1 = serial transfer, 0 = latched parallel |
| holdoff_en | input | 1 | Apply the post-update holdoff to this command |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial bit clock |
| latch_en | output | 1 | Latch strobe |
| par_code | output | 6 | Parallel code lines |

## Verification
The hardest case to reach is a command that waits behind a busy block. The new code has to stay out of both the serial stream and the parallel lines until the holdoff has expired, and only then may it be taken. The stimulus creates this in two ways. It keeps `cmd_valid` high with a different code while a transfer is running. It also issues a parallel command directly after a serial one whose holdoff is armed. A bench model that follows the ports cycle by cycle catches any early acceptance or any leak of the pending code. A separate monitor measures the time from the strobe falling to `cmd_ready` rising, with the holdoff both on and off.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOW,
      ST_SHIGH,
      ST_SGAP,
      ST_STROBE,
      ST_PSETUP,
      ST_PHOLD,
      ST_WAIT
   } ap_state_e;

   // round a time up to whole clock cycles, never less than one
   function automatic int unsigned to_cycles(input int unsigned t_ps, input int unsigned clk_ps);
      int unsigned r;
      r = (t_ps + clk_ps - 1) / clk_ps;
      return (r == 0) ? 1 : r;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/atten_tick_timer.sv
module atten_tick_timer #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/atten_bit_shifter.sv
module atten_bit_shifter #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         clear,
   output logic         msb
);
   logic [W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr <= '0;
      else if (load)     sr <= load_val;
      else if (clear)    sr <= '0;
      else if (shift)    sr <= {sr[W-2:0], 1'b0};
   end

   assign msb = sr[W-1];
endmodule

// File: rtl/atten_prog.sv
module atten_prog
   import atten_prog_pkg::*;
#(
   parameter int unsigned CODE_W     = 6,
   parameter int unsigned CLK_PS     = 8000,
   parameter int unsigned CLKH_PS    = 30000,
   parameter int unsigned CLKL_PS    = 30000,
   parameter int unsigned CLKPER_PS  = 100000,
   parameter int unsigned DSU_PS     = 10000,
   parameter int unsigned DHD_PS     = 10000,
   parameter int unsigned LESU_PS    = 10000,
   parameter int unsigned SLEPW_PS   = 30000,
   parameter int unsigned PSU_PS     = 10000,
   parameter int unsigned PLEPW_PS   = 10000,
   parameter int unsigned PHD_PS     = 10000,
   parameter int unsigned HOLDOFF_PS = 40000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [CODE_W-1:0] cmd_code,
   input  logic              cmd_serial,
   input  logic              holdoff_en,
   output logic              ser_data,
   output logic              ser_clk,
   output logic              latch_en,
   output logic [CODE_W-1:0] par_code
);
   localparam int unsigned HI_CYC   = umax(to_cycles(CLKH_PS, CLK_PS), to_cycles(DHD_PS, CLK_PS));
   localparam int unsigned PER_CYC  = to_cycles(CLKPER_PS, CLK_PS);
   localparam int unsigned LO_CYC   = umax(umax(to_cycles(CLKL_PS, CLK_PS), to_cycles(DSU_PS, CLK_PS)),
                                           (PER_CYC > HI_CYC) ? PER_CYC - HI_CYC : 1);
   localparam int unsigned GAP_CYC  = to_cycles(LESU_PS, CLK_PS);
   localparam int unsigned SLE_CYC  = to_cycles(SLEPW_PS, CLK_PS);
   localparam int unsigned PSU_CYC  = to_cycles(PSU_PS, CLK_PS);
   localparam int unsigned PLE_CYC  = to_cycles(PLEPW_PS, CLK_PS);
   localparam int unsigned PHD_CYC  = to_cycles(PHD_PS, CLK_PS);
   localparam int unsigned HOLD_CYC = to_cycles(HOLDOFF_PS, CLK_PS);
   localparam int unsigned MAX_CYC  = umax(umax(umax(HI_CYC, LO_CYC), umax(GAP_CYC, SLE_CYC)),
                                           umax(umax(PSU_CYC, PLE_CYC), umax(PHD_CYC, HOLD_CYC)));
   localparam int unsigned TW       = $clog2(MAX_CYC + 1);
   localparam int unsigned BW       = $clog2(CODE_W);

   if (CODE_W < 2) begin : g_bad_width
      $error("atten_prog: CODE_W must be at least 2");
   end
   if (CLK_PS == 0) begin : g_bad_clk
      $error("atten_prog: CLK_PS must be nonzero");
   end

   ap_state_e      st, nxt;
   logic           tmr_load, tmr_exp;
   logic [TW-1:0]  tmr_val;
   logic           sh_load, sh_shift, sh_clr, par_load;
   logic [BW-1:0]  bit_idx;
   logic           mode_par_q, hold_q, hold_take;
   logic           sclk_q, le_q;
   logic [CODE_W-1:0] par_q;

   // holdoff variant: removed entirely when the spacing parameter is zero
   if (HOLDOFF_PS == 0) begin : g_no_hold
      logic unused_hold;
      assign unused_hold = holdoff_en;
      assign hold_take   = 1'b0;
   end else begin : g_hold
      assign hold_take = holdoff_en;
   end

   atten_tick_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
   );

   atten_bit_shifter #(.W(CODE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(cmd_code),
      .shift(sh_shift), .clear(sh_clr), .msb(ser_data)
   );

   always_comb begin
      nxt      = st;
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      sh_clr   = 1'b0;
      par_load = 1'b0;
      unique case (st)
         ST_IDLE: if (cmd_valid) begin
            tmr_load = 1'b1;
            if (cmd_serial) begin
               nxt = ST_SLOW; tmr_val = TW'(LO_CYC - 1); sh_load = 1'b1;
            end else begin
               nxt = ST_PSETUP; tmr_val = TW'(PSU_CYC - 1); par_load = 1'b1;
            end
         end
         ST_SLOW: if (tmr_exp) begin
            nxt = ST_SHIGH; tmr_load = 1'b1; tmr_val = TW'(HI_CYC - 1);
         end
         ST_SHIGH: if (tmr_exp) begin
            tmr_load = 1'b1;
            if (bit_idx == '0) begin
               nxt = ST_SGAP; tmr_val = TW'(GAP_CYC - 1);
            end else begin
               nxt = ST_SLOW; tmr_val = TW'(LO_CYC - 1); sh_shift = 1'b1;
            end
         end
         ST_SGAP: if (tmr_exp) begin
            nxt = ST_STROBE; tmr_load = 1'b1; tmr_val = TW'(SLE_CYC - 1);
         end
         ST_PSETUP: if (tmr_exp) begin
            nxt = ST_STROBE; tmr_load = 1'b1; tmr_val = TW'(PLE_CYC - 1);
         end
         ST_STROBE: if (tmr_exp) begin
            tmr_load = 1'b1;
            if (mode_par_q) begin
               nxt = ST_PHOLD; tmr_val = TW'(PHD_CYC - 1);
            end else begin
               sh_clr  = 1'b1;
               nxt     = hold_q ? ST_WAIT : ST_IDLE;
               tmr_val = TW'(HOLD_CYC - 1);
            end
         end
         ST_PHOLD: if (tmr_exp) begin
            nxt = hold_q ? ST_WAIT : ST_IDLE; tmr_load = 1'b1; tmr_val = TW'(HOLD_CYC - 1);
         end
         ST_WAIT: if (tmr_exp) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         sclk_q     <= 1'b0;
         le_q       <= 1'b0;
         par_q      <= '0;
         bit_idx    <= '0;
         mode_par_q <= 1'b0;
         hold_q     <= 1'b0;
      end else begin
         st     <= nxt;
         sclk_q <= (nxt == ST_SHIGH);
         le_q   <= (nxt == ST_STROBE);
         if (par_load) par_q <= cmd_code;
         if (st == ST_IDLE && cmd_valid) begin
            mode_par_q <= ~cmd_serial;
            hold_q     <= hold_take;
            bit_idx    <= BW'(CODE_W - 1);
         end else if (sh_shift) begin
            bit_idx <= bit_idx - 1'b1;
         end
      end
   end

   assign cmd_ready = (st == ST_IDLE);
   assign ser_clk   = sclk_q;
   assign latch_en  = le_q;
   assign par_code  = par_q;
endmodule

// File: rtl/atten_prog_chk.sv
module atten_prog_chk #(
   parameter int unsigned CODE_W = 6,
   parameter int unsigned HI_MIN = 4,
   parameter int unsigned LO_MIN = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              ser_clk,
   input logic              ser_data,
   input logic              latch_en,
   input logic [CODE_W-1:0] par_code
);
   logic [15:0] hi_len, lo_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len <= '0;
         lo_len <= '0;
      end else begin
         hi_len <= ser_clk ? ((hi_len == 16'hFFFF) ? hi_len : hi_len + 1'b1) : '0;
         lo_len <= ser_clk ? '0 : ((lo_len == 16'hFFFF) ? lo_len : lo_len + 1'b1);
      end
   end

   // R2: bit clock phases meet their minimum lengths
   p_clk_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> hi_len >= 16'(HI_MIN));
   p_clk_low_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> lo_len >= 16'(LO_MIN));

   // R1: data never moves while the bit clock is high
   p_data_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   // R3: strobe and bit clock are never high together
   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en |-> !ser_clk);

   // R5: parallel lines frozen while the strobe is high and in the cycle it falls
   p_par_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en || $fell(latch_en)) |-> $stable(par_code));

   // R8: an idle block drives no activity
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!ser_clk && !latch_en));
endmodule

bind atten_prog atten_prog_chk #(
   .CODE_W(CODE_W), .HI_MIN(HI_CYC), .LO_MIN(LO_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .ser_clk(ser_clk),
   .ser_data(ser_data), .latch_en(latch_en), .par_code(par_code)
);

// File: tb/tb_atten_prog.sv
`timescale 1ns/1ps
module tb_atten_prog;
   // expected cycle counts at an 8 ns clock, from the requirements
   localparam int LO = 9, HI = 4, GAP = 2, SLE = 4, PSU = 2, PLE = 2, PHD = 2, HOLD = 5000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_serial = 1'b0, holdoff_en = 1'b0;
   logic [5:0] cmd_code = '0;
   logic cmd_ready, ser_data, ser_clk, latch_en;
   logic [5:0] par_code;

   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   atten_prog dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_code(cmd_code), .cmd_serial(cmd_serial), .holdoff_en(holdoff_en),
      .ser_data(ser_data), .ser_clk(ser_clk), .latch_en(latch_en), .par_code(par_code)
   );

   // reference model: {ready, le, sclk, sdata, par[5:0]}
   logic [9:0] q[$];
   logic [9:0] exp_v = 10'b1000_000000;
   logic [5:0] m_par = '0;
   logic       m_acc = 1'b0;

   function automatic logic [9:0] ent(input logic r, input logic l, input logic c,
                                      input logic d, input logic [5:0] p);
      return {r, l, c, d, p};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); m_par = '0; m_acc = 1'b0; exp_v = ent(1, 0, 0, 0, 6'd0);
      end else begin
         m_acc = 1'b0;
         if (cmd_valid && exp_v[9]) begin
            m_acc = 1'b1;
            if (cmd_serial) begin
               for (int b = 5; b >= 0; b--) begin
                  repeat (LO) q.push_back(ent(0, 0, 0, cmd_code[b], m_par));
                  repeat (HI) q.push_back(ent(0, 0, 1, cmd_code[b], m_par));
               end
               repeat (GAP) q.push_back(ent(0, 0, 0, cmd_code[0], m_par));
               repeat (SLE) q.push_back(ent(0, 1, 0, cmd_code[0], m_par));
            end else begin
               m_par = cmd_code;
               repeat (PSU) q.push_back(ent(0, 0, 0, 0, m_par));
               repeat (PLE) q.push_back(ent(0, 1, 0, 0, m_par));
               repeat (PHD) q.push_back(ent(0, 0, 0, 0, m_par));
            end
            if (holdoff_en) repeat (HOLD) q.push_back(ent(0, 0, 0, 0, m_par));
         end
         exp_v = (q.size() > 0) ? q.pop_front() : ent(1, 0, 0, 0, m_par);
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if ({cmd_ready, latch_en, ser_clk, ser_data, par_code} !== exp_v) begin
            errors++;
            if (ser_data !== exp_v[6])  $display("FAIL R1 ser_data got %b exp %b t=%0t", ser_data, exp_v[6], $time);
            if (ser_clk !== exp_v[7])   $display("FAIL R2 ser_clk got %b exp %b t=%0t", ser_clk, exp_v[7], $time);
            if (latch_en !== exp_v[8])  $display("FAIL R3 or R5 latch_en got %b exp %b t=%0t", latch_en, exp_v[8], $time);
            if (par_code !== exp_v[5:0]) $display("FAIL R5 par_code got %h exp %h t=%0t", par_code, exp_v[5:0], $time);
            if (cmd_ready !== exp_v[9]) $display("FAIL R4 R7 cmd_ready got %b exp %b t=%0t", cmd_ready, exp_v[9], $time);
         end
      end
   end

   // R6 monitor: cycles with ready low from the strobe falling
   logic prev_le = 1'b0, gcount = 1'b0;
   int gapc = 0, last_gap = -1;
   always @(negedge clk) begin
      if (prev_le && !latch_en) begin gcount = 1'b1; gapc = 0; end
      if (gcount) begin
         if (!cmd_ready) gapc++;
         else begin gcount = 1'b0; last_gap = gapc; end
      end
      prev_le = latch_en;
   end

   task automatic send(input logic [5:0] c, input logic s, input logic h);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = c; cmd_serial = s; holdoff_en = h;
      do begin @(posedge clk); #1; end while (!m_acc);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!cmd_ready);
      @(negedge clk);
   endtask

   task automatic chk_gap(input int expv, input string tag);
      checks++;
      if (last_gap != expv) begin
         errors++;
         $display("FAIL R6 %s gap got %0d exp %0d", tag, last_gap, expv);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state
      checks++;
      if ({cmd_ready, ser_clk, latch_en, ser_data, par_code} !== {4'b1000, 6'd0}) begin
         errors++;
         $display("FAIL R8 reset got %b exp %b",
                  {cmd_ready, ser_clk, latch_en, ser_data, par_code}, {4'b1000, 6'd0});
      end
      // R1 R2 R3 R4: serial patterns without holdoff
      send(6'b101101, 1, 0); wait_idle(); chk_gap(0, "serial no holdoff");
      // R5: parallel
      send(6'b110010, 1'b0, 0); wait_idle(); chk_gap(PHD, "parallel no holdoff");
      // R8: serial leaves par_code alone
      send(6'b000001, 1, 0); wait_idle();
      send(6'b111111, 1, 0); wait_idle();
      send(6'b000000, 1, 0); wait_idle();
      send(6'b000000, 1'b0, 0); wait_idle();
      send(6'b111111, 1'b0, 0); wait_idle();
      // R7: command held while busy is not taken
      send(6'b101010, 1, 0);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 6'b010101; cmd_serial = 1'b0;
      repeat (20) @(negedge clk);
      cmd_valid = 1'b0;
      wait_idle();
      // R6: holdoff armed, next command waits behind it
      send(6'b011010, 1, 1);
      send(6'b100101, 1'b0, 0);
      chk_gap(HOLD, "serial with holdoff");
      wait_idle();
      send(6'b001100, 1'b0, 1); wait_idle(); chk_gap(PHD + HOLD, "parallel with holdoff");
      repeat (10) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule